// File: doc/BRIEF.md
# Packed Decimal Arithmetic Unit with Condition Codes

This block performs one arithmetic step on packed binary-coded-decimal operands: decimal add, decimal subtract or decimal negate, each folding in an extend bit. It can also do extended binary add and subtract. Each digit is first combined in binary and then adjusted by a correction of six, so the result is again valid packed decimal. Alongside the result the block returns a new five-bit condition code set. That set is built from the corrected result and the condition codes supplied with the request.

The zero flag is treated as a running accumulation across a chain of bytes. A nonzero result clears it, and a zero result leaves it as it came in. A wide decimal number can therefore be processed one byte at a time, feeding each step's condition codes into the next. The zero flag reflects the whole number only if the caller presets it to 1 before the first byte. A request is a one-cycle `start` strobe. The result and flags are registered on that edge, and `done_o` is high for exactly the following cycle.

Top module: `bcd_alu`

## Requirements
- R1: With op_sel = 0 (decimal add), result = dst + src + X in packed decimal. Every digit whose binary sum exceeds 9 is increased by 6 and carries one into the next digit.
- R2: With op_sel = 1 (decimal subtract), result = dst − src − X in packed decimal. Every digit that borrows is decreased by 6 and borrows one from the next digit.
- R3: With op_sel = 2 (decimal negate), result = 0 − dst − X in packed decimal, and src_i has no effect on the result or on the flags.
- R4: For every supported operation, the outgoing Z flag is cleared if the corrected result is nonzero. If the corrected result is zero, Z equals the incoming Z. The flag is never set by the operation.
- R5: Condition code bit positions are X=4, N=3, Z=2, V=1, C=0. For decimal operations X and C both equal the carry or borrow out of the top digit, N equals the top bit of the corrected result, and V is 0.
- R6: With ENABLE_BINARY set, op_sel = 3 computes dst + src + X and op_sel = 4 computes dst − src − X in binary. In both, C = X = carry (add) or borrow (subtract), V = signed two's-complement overflow, N = top result bit, and Z follows R4.
- R7: For any op_sel not listed as supported (5 to 7, and also 3 and 4 when ENABLE_BINARY is 0), the result equals dst_i and the condition codes equal ccr_i unchanged.
- R8: Result and flags are captured on the rising edge where start is high. done_o is high in the cycle after that edge only. Result and flags hold their values while start is low.
- R9: While rst_n is low, result_o, ccr_o and done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one operation per high cycle |
| op_sel | input | 3 | Operation code (0 dec add, 1 dec sub, 2 dec negate, 3 bin add-x, 4 bin sub-x) |
| dst_i | input | 4*DIGITS | Destination operand (minuend / first addend) |
| src_i | input | 4*DIGITS | Source operand |
| ccr_i | input | 5 | Prior condition codes {X,N,Z,V,C} |
| result_o | output | 4*DIGITS | Registered result |
| ccr_o | output | 5 | Registered condition codes {X,N,Z,V,C} |
| done_o | output | 1 | One-cycle pulse after a request |

## Verification
The bench builds the unit with DIGITS = 2 and ENABLE_BINARY = 1. That gives an 8-bit operand, so the carry between the two digit stages is exercised and the all-nines wrap on subtract and negate can be reached. The binary variant is enabled, so the extended add and subtract paths, with their signed overflow cases at 0x7F and 0x80, can be checked against the same clear-only zero rule. A two-byte chained addition shows that an all-zero low byte keeps Z while a nonzero high byte clears it.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

   localparam int CCR_W = 5;
   localparam int F_EXT = 4;
   localparam int F_NEG = 3;
   localparam int F_ZER = 2;
   localparam int F_OVF = 1;
   localparam int F_CAR = 0;

   typedef enum logic [2:0] {
      OP_DADD = 3'd0,
      OP_DSUB = 3'd1,
      OP_DNEG = 3'd2,
      OP_BADD = 3'd3,
      OP_BSUB = 3'd4
   } op_e;

   typedef logic [CCR_W-1:0] ccr_t;

endpackage

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain #(
   parameter int DIGITS   = 2,
   parameter bit SUBTRACT = 1'b0,
   localparam int W = 4 * DIGITS
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         cout_o
);

   logic [DIGITS:0] link;
   assign link[0] = cin_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_nib
      logic [4:0] raw;
      logic       adj;
      if (SUBTRACT) begin : g_sub
         always_comb begin
            raw = {1'b0, a_i[4*g +: 4]} - {1'b0, b_i[4*g +: 4]} - {4'b0, link[g]};
            adj = raw[4];
         end
         assign r_o[4*g +: 4] = adj ? (raw[3:0] - 4'd6) : raw[3:0];
      end else begin : g_add
         always_comb begin
            raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + {4'b0, link[g]};
            adj = (raw > 5'd9);
         end
         assign r_o[4*g +: 4] = adj ? (raw[3:0] + 4'd6) : raw[3:0];
      end
      assign link[g+1] = adj;
   end

   assign cout_o = link[DIGITS];

endmodule

// File: rtl/bin_ext_unit.sv
module bin_ext_unit #(
   parameter int W        = 8,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] r_o,
   output logic         cout_o,
   output logic         ovf_o
);

   logic [W:0] wide;

   if (SUBTRACT) begin : g_sub
      always_comb begin
         wide  = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
         ovf_o = (a_i[W-1] != b_i[W-1]) && (wide[W-1] != a_i[W-1]);
      end
   end else begin : g_add
      always_comb begin
         wide  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
         ovf_o = (a_i[W-1] == b_i[W-1]) && (wide[W-1] != a_i[W-1]);
      end
   end

   assign r_o    = wide[W-1:0];
   assign cout_o = wide[W];

endmodule

// File: rtl/ccr_merge.sv
module ccr_merge
   import bcd_alu_pkg::*;
(
   input  ccr_t prior_i,
   input  ccr_t fresh_i,
   input  ccr_t mask_i,
   output ccr_t ccr_o
);

   for (genvar b = 0; b < CCR_W; b++) begin : g_bit
      if (b == F_ZER) begin : g_zero
         assign ccr_o[b] = mask_i[b] ? (prior_i[b] & fresh_i[b]) : prior_i[b];
      end else begin : g_plain
         assign ccr_o[b] = mask_i[b] ? fresh_i[b] : prior_i[b];
      end
   end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
   import bcd_alu_pkg::*;
#(
   parameter int DIGITS        = 2,
   parameter bit ENABLE_BINARY = 1'b1,
   localparam int W = 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   op_sel,
   input  logic [W-1:0] dst_i,
   input  logic [W-1:0] src_i,
   input  logic [4:0]   ccr_i,
   output logic [W-1:0] result_o,
   output logic [4:0]   ccr_o,
   output logic         done_o
);

   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_alu: DIGITS must be at least 1");
   end

   logic         x_in;
   assign x_in = ccr_i[F_EXT];

   logic [W-1:0] dadd_r, dsub_r, dneg_r;
   logic         dadd_c, dsub_c, dneg_c;

   bcd_digit_chain #(.DIGITS(DIGITS), .SUBTRACT(1'b0)) u_dadd (
      .a_i(dst_i), .b_i(src_i), .cin_i(x_in), .r_o(dadd_r), .cout_o(dadd_c));

   bcd_digit_chain #(.DIGITS(DIGITS), .SUBTRACT(1'b1)) u_dsub (
      .a_i(dst_i), .b_i(src_i), .cin_i(x_in), .r_o(dsub_r), .cout_o(dsub_c));

   bcd_digit_chain #(.DIGITS(DIGITS), .SUBTRACT(1'b1)) u_dneg (
      .a_i({W{1'b0}}), .b_i(dst_i), .cin_i(x_in), .r_o(dneg_r), .cout_o(dneg_c));

   logic [W-1:0] badd_r, bsub_r;
   logic         badd_c, bsub_c, badd_v, bsub_v;

   if (ENABLE_BINARY) begin : g_bin
      bin_ext_unit #(.W(W), .SUBTRACT(1'b0)) u_badd (
         .a_i(dst_i), .b_i(src_i), .cin_i(x_in),
         .r_o(badd_r), .cout_o(badd_c), .ovf_o(badd_v));
      bin_ext_unit #(.W(W), .SUBTRACT(1'b1)) u_bsub (
         .a_i(dst_i), .b_i(src_i), .cin_i(x_in),
         .r_o(bsub_r), .cout_o(bsub_c), .ovf_o(bsub_v));
   end else begin : g_nobin
      assign badd_r = '0;
      assign bsub_r = '0;
      assign badd_c = 1'b0;
      assign bsub_c = 1'b0;
      assign badd_v = 1'b0;
      assign bsub_v = 1'b0;
   end

   logic [W-1:0] res_d;
   logic         car_d, ovf_d;
   ccr_t         mask_d, fresh_d, merged_d;

   always_comb begin
      res_d  = dst_i;
      car_d  = 1'b0;
      ovf_d  = 1'b0;
      mask_d = '0;
      case (op_sel)
         OP_DADD: begin res_d = dadd_r; car_d = dadd_c; mask_d = '1; end
         OP_DSUB: begin res_d = dsub_r; car_d = dsub_c; mask_d = '1; end
         OP_DNEG: begin res_d = dneg_r; car_d = dneg_c; mask_d = '1; end
         OP_BADD: if (ENABLE_BINARY) begin
            res_d = badd_r; car_d = badd_c; ovf_d = badd_v; mask_d = '1;
         end
         OP_BSUB: if (ENABLE_BINARY) begin
            res_d = bsub_r; car_d = bsub_c; ovf_d = bsub_v; mask_d = '1;
         end
         default: ;
      endcase
      fresh_d        = '0;
      fresh_d[F_EXT] = car_d;
      fresh_d[F_NEG] = res_d[W-1];
      fresh_d[F_ZER] = (res_d == '0);
      fresh_d[F_OVF] = ovf_d;
      fresh_d[F_CAR] = car_d;
   end

   ccr_merge u_merge (
      .prior_i(ccr_i), .fresh_i(fresh_d), .mask_i(mask_d), .ccr_o(merged_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         ccr_o    <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start;
         if (start) begin
            result_o <= res_d;
            ccr_o    <= merged_d;
         end
      end
   end

endmodule

// File: rtl/bcd_alu_checker.sv
module bcd_alu_checker
   import bcd_alu_pkg::*;
#(
   parameter int DIGITS        = 2,
   parameter bit ENABLE_BINARY = 1'b1,
   localparam int W = 4 * DIGITS
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [2:0]   op_sel,
   input logic [W-1:0] dst_i,
   input logic [4:0]   ccr_i,
   input logic [W-1:0] result_o,
   input logic [4:0]   ccr_o,
   input logic         done_o
);

   logic unsupported;
   assign unsupported = (op_sel > 3'd4) || (!ENABLE_BINARY && (op_sel > 3'd2));

   a_r8_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done_o);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done_o);

   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result_o) && $stable(ccr_o)));

   a_r4_z_never_set: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ccr_i[F_ZER]) |=> !ccr_o[F_ZER]);

   a_r5_decimal_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (op_sel <= 3'd2)) |=>
         (ccr_o[F_EXT] == ccr_o[F_CAR]) && !ccr_o[F_OVF] && (ccr_o[F_NEG] == result_o[W-1]));

   a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (start && unsupported) |=> (result_o == $past(dst_i)) && (ccr_o == $past(ccr_i)));

endmodule

bind bcd_alu bcd_alu_checker #(.DIGITS(DIGITS), .ENABLE_BINARY(ENABLE_BINARY)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .dst_i(dst_i),
   .ccr_i(ccr_i), .result_o(result_o), .ccr_o(ccr_o), .done_o(done_o));

// File: tb/bcd_alu_test.sv
module bcd_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] op_sel = '0;
   logic [7:0] dst_i = '0;
   logic [7:0] src_i = '0;
   logic [4:0] ccr_i = '0;
   logic [7:0] result_o;
   logic [4:0] ccr_o;
   logic       done_o;

   int errors = 0;
   int checks = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   bcd_alu #(.DIGITS(2), .ENABLE_BINARY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .dst_i(dst_i), .src_i(src_i), .ccr_i(ccr_i),
      .result_o(result_o), .ccr_o(ccr_o), .done_o(done_o));

   // {op, dst, src, ccr_in, exp_result, exp_ccr}; ccr is {X,N,Z,V,C}
   localparam int NV = 18;
   localparam logic [36:0] VEC [NV] = '{
      {3'd0, 8'h45, 8'h38, 5'h04, 8'h83, 5'h08},  // R1 R4 digit carry, Z cleared
      {3'd0, 8'h99, 8'h01, 5'h04, 8'h00, 5'h15},  // R1 R4 R5 wrap, Z kept set
      {3'd0, 8'h99, 8'h01, 5'h00, 8'h00, 5'h11},  // R4 zero result does not set Z
      {3'd0, 8'h12, 8'h34, 5'h13, 8'h47, 5'h00},  // R1 R5 X in, V forced 0
      {3'd1, 8'h45, 8'h38, 5'h04, 8'h07, 5'h00},  // R2 digit borrow
      {3'd1, 8'h10, 8'h20, 5'h04, 8'h90, 5'h19},  // R2 R5 borrow out, N set
      {3'd1, 8'h00, 8'h00, 5'h14, 8'h99, 5'h19},  // R2 X borrow wraps to 99
      {3'd2, 8'h00, 8'hFF, 5'h04, 8'h00, 5'h04},  // R3 R4 negate zero keeps Z
      {3'd2, 8'h01, 8'hFF, 5'h00, 8'h99, 5'h19},  // R3 negate one
      {3'd2, 8'h25, 8'h00, 5'h14, 8'h74, 5'h11},  // R3 with X
      {3'd2, 8'h25, 8'h99, 5'h14, 8'h74, 5'h11},  // R3 src ignored
      {3'd3, 8'h7F, 8'h00, 5'h14, 8'h80, 5'h0A},  // R6 add overflow
      {3'd3, 8'hFF, 8'h01, 5'h04, 8'h00, 5'h15},  // R6 R4 carry, Z kept
      {3'd4, 8'h00, 8'h01, 5'h04, 8'hFF, 5'h19},  // R6 borrow
      {3'd4, 8'h80, 8'h01, 5'h00, 8'h7F, 5'h02},  // R6 sub overflow
      {3'd5, 8'h33, 8'h11, 5'h1F, 8'h33, 5'h1F},  // R7 unsupported
      {3'd6, 8'h00, 8'h22, 5'h0A, 8'h00, 5'h0A},  // R7 unsupported
      {3'd7, 8'hA5, 8'h5A, 5'h00, 8'hA5, 5'h00}   // R7 unsupported
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [7:0] s,
                        input logic [4:0] c);
      op_sel = op; dst_i = d; src_i = s; ccr_i = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!ended) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] lo_res;
      logic [4:0] lo_ccr;
      repeat (3) @(negedge clk);
      chk("R9 result in reset", {24'b0, result_o}, 32'h0);
      chk("R9 ccr in reset", {27'b0, ccr_o}, 32'h0);
      chk("R9 done in reset", {31'b0, done_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 no done without start", {31'b0, done_o}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:13]);
         chk($sformatf("R8 done vec %0d", i), {31'b0, done_o}, 32'h1);
         chk($sformatf("R1-family result vec %0d (R1 R2 R3 R6 R7)", i),
             {24'b0, result_o}, {24'b0, VEC[i][12:5]});
         chk($sformatf("flags vec %0d (R4 R5 R6 R7)", i),
             {27'b0, ccr_o}, {27'b0, VEC[i][4:0]});
      end

      // R8: done is a single pulse, outputs hold with start low and changed inputs
      op_sel = 3'd0; dst_i = 8'h11; src_i = 8'h22; ccr_i = 5'h1F;
      @(negedge clk);
      chk("R8 done pulse ends", {31'b0, done_o}, 32'h0);
      chk("R8 result holds", {24'b0, result_o}, 32'hA5);
      chk("R8 ccr holds", {27'b0, ccr_o}, 32'h00);

      // R4 chained two-byte decimal add: 0199 + 0001 = 0200, Z cleared by high byte
      issue(3'd0, 8'h99, 8'h01, 5'h04);
      lo_res = result_o; lo_ccr = ccr_o;
      chk("R4 chain low byte", {24'b0, lo_res}, 32'h00);
      chk("R4 chain low Z kept", {31'b0, lo_ccr[2]}, 32'h1);
      issue(3'd0, 8'h01, 8'h00, lo_ccr);
      chk("R1 chain high byte", {24'b0, result_o}, 32'h02);
      chk("R4 chain high Z cleared", {27'b0, ccr_o}, 32'h00);

      // R9: reset mid-operation clears outputs
      issue(3'd1, 8'h10, 8'h20, 5'h04);
      rst_n = 1'b0;
      #1;
      chk("R9 async reset result", {24'b0, result_o}, 32'h0);
      chk("R9 async reset ccr", {27'b0, ccr_o}, 32'h0);
      chk("R9 async reset done", {31'b0, done_o}, 32'h0);

      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule